// File: doc/BRIEF.md
# Protected Oscillator Rate Switch

This block controls the rate of a dual-speed high-frequency oscillator (16 MHz or 32 MHz) that feeds an analog-side clock domain. The oscillator edges arrive as single-cycle tick strobes sampled by a fast register clock. Every output is a registered tick strobe in that same register clock domain. The block produces four results from the ticks. The first is an analog clock enable, which software can gate off. The second is a converter clock enable, which is never divided and never gated. The third is a system clock enable, produced by a post-divider fed from the analog clock. The fourth is a select line that drives the oscillator itself.

The rate select sits in a protected configuration register. Software changes the rate in three steps. It first gates the analog clock off. It then presents the unlock key and writes the configuration register. Finally it re-enables the analog clock. The key is good for a single protected write. A protected write that arrives at the wrong time is dropped and raises a sticky error flag. While 32 MHz is selected, the post-divider never divides by less than two, so the derived system clock stays at or below 16 MHz.

Top module: `hfosc_rate_ctrl`

## Requirements
- R1: A write of KEY_VALUE (default 16'hB7E1) to address 0 arms the unlock. A write of any other value to address 0 disarms it. A write to the configuration register (address 1) is accepted only while the unlock is armed.
- R2: In an accepted configuration write, data bit 2 = 0 selects 32 MHz (`osc_sel32` = 1) and data bit 2 = 1 selects 16 MHz (`osc_sel32` = 0). All other data bits have no effect.
- R3: A configuration write is accepted only while the analog clock is gated off. A configuration write that arrives while the analog clock is enabled leaves the rate unchanged and sets `prot_err`. `prot_err` stays set until reset.
- R4: After reset, `osc_sel32` = 0 (16 MHz), the analog clock is enabled, the divider field is 1, the unlock is disarmed, and all outputs are 0.
- R5: The divider field is data bits [5:0] of a write to address 3. The field maps to a ratio: 0 gives 1, values 1..32 give themselves, and values above 32 give 32. `sys_tick` pulses once for every ratio's worth of analog clock ticks.
- R6: While 32 MHz is selected and the ratio from R5 is below 2, the ratio used is 2 and `div_forced` reads 1. In every other case `div_forced` reads 0.
- R7: `conv_tick` repeats the selected oscillator's tick one cycle later, undivided, whatever the gate state. A tick on the oscillator that is not selected has no effect.
- R8: Address 2 holds the gate in data bit 0, where 1 means gated off. While the gate is off, `aclk_tick` and `sys_tick` stay 0.
- R9: The unlock is spent by any configuration write, whether accepted or not. A configuration write made while the unlock is not armed is ignored and sets `prot_err`.
- R10: A divider write restarts the divide count. No `sys_tick` is produced for a tick that falls in the same cycle as the divider write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 key, 1 config, 2 gate, 3 divider |
| wr_data | input | 16 | Register write data |
| osc16_tick | input | 1 | Tick strobe from the oscillator's 16 MHz output |
| osc32_tick | input | 1 | Tick strobe from the oscillator's 32 MHz output |
| osc_sel32 | output | 1 | Rate select to the oscillator (1 = 32 MHz) |
| aclk_tick | output | 1 | Gated analog clock enable |
| sys_tick | output | 1 | Divided system clock enable |
| conv_tick | output | 1 | Undivided converter clock enable |
| prot_err | output | 1 | Sticky protection error |
| div_forced | output | 1 | Divider raised to its 32 MHz floor |

## Verification
Two functions can fall in the same cycle: a divider write and an oscillator tick. The bench provokes this by driving a divider write of ratio 1 in the same cycle as a 16 MHz tick. It then judges the result at the ports. The converter output must still show the tick. The system output must stay low, because the count restart wins over the tick. A second case of the same kind is a rejected configuration write that arrives while the clock is enabled and the unlock is armed. The bench checks that this write both raises the error and spends the key.

// File: rtl/hfosc_pkg.sv
package hfosc_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_KEY  = 2'd0,
    REG_CFG  = 2'd1,
    REG_GATE = 2'd2,
    REG_DIV  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/hfosc_keylock.sv
module hfosc_keylock
  import hfosc_pkg::*;
#(
  parameter int                DATA_W    = 16,
  parameter logic [DATA_W-1:0] KEY_VALUE = 16'hB7E1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                gate_off,
  output logic                cfg_accept,
  output logic                prot_err
);
  logic armed_q;
  logic key_wr;
  logic cfg_wr;

  assign key_wr     = wr_en && (wr_addr == REG_KEY);
  assign cfg_wr     = wr_en && (wr_addr == REG_CFG);
  assign cfg_accept = cfg_wr && armed_q && gate_off;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q  <= 1'b0;
      prot_err <= 1'b0;
    end else begin
      if (key_wr)      armed_q <= (wr_data == KEY_VALUE);
      else if (cfg_wr) armed_q <= 1'b0;
      if (cfg_wr && !cfg_accept) prot_err <= 1'b1;
    end
  end

  // R9: any config write spends the key
  assert_key_single_use_R9: assert property (@(posedge clk) disable iff (rst)
    cfg_wr |=> !armed_q);
  // R3: error is sticky
  assert_err_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    prot_err |=> prot_err);
endmodule

// File: rtl/hfosc_sysdiv.sv
module hfosc_sysdiv #(
  parameter int DIV_W   = 6,
  parameter int DIV_MAX = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             div_wr,
  input  logic [DIV_W-1:0] div_data,
  input  logic             sel32,
  input  logic             gated_tick,
  output logic             sys_tick,
  output logic             div_forced
);
  localparam logic [DIV_W-1:0] RATIO_MAX   = DIV_MAX[DIV_W-1:0];
  localparam logic [DIV_W-1:0] RATIO_FLOOR = DIV_W'(2);
  localparam logic [DIV_W-1:0] ONE         = DIV_W'(1);

  logic [DIV_W-1:0] field_q;
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] ratio_clamped;
  logic [DIV_W-1:0] ratio_eff;
  logic             forced_now;

  always_comb begin
    if (field_q == '0)           ratio_clamped = ONE;
    else if (field_q > RATIO_MAX) ratio_clamped = RATIO_MAX;
    else                          ratio_clamped = field_q;
    forced_now = sel32 && (ratio_clamped < RATIO_FLOOR);
    ratio_eff  = forced_now ? RATIO_FLOOR : ratio_clamped;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      field_q    <= ONE;
      cnt_q      <= '0;
      sys_tick   <= 1'b0;
      div_forced <= 1'b0;
    end else begin
      div_forced <= forced_now;
      if (div_wr) begin
        field_q  <= div_data;
        cnt_q    <= '0;
        sys_tick <= 1'b0;
      end else if (gated_tick) begin
        if (cnt_q >= ratio_eff - ONE) begin
          cnt_q    <= '0;
          sys_tick <= 1'b1;
        end else begin
          cnt_q    <= cnt_q + ONE;
          sys_tick <= 1'b0;
        end
      end else begin
        sys_tick <= 1'b0;
      end
    end
  end

  // R6: at 32 MHz the system tick never repeats on back-to-back cycles
  assert_div_floor_R6: assert property (@(posedge clk) disable iff (rst)
    (sel32 && sys_tick) |=> !sys_tick);
endmodule

// File: rtl/hfosc_rate_ctrl.sv
module hfosc_rate_ctrl
  import hfosc_pkg::*;
#(
  parameter int                DATA_W    = 16,
  parameter logic [DATA_W-1:0] KEY_VALUE = 16'hB7E1,
  parameter int                RATE_BIT  = 2,
  parameter int                DIV_W     = 6,
  parameter int                DIV_MAX   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              osc16_tick,
  input  logic              osc32_tick,
  output logic              osc_sel32,
  output logic              aclk_tick,
  output logic              sys_tick,
  output logic              conv_tick,
  output logic              prot_err,
  output logic              div_forced
);
  logic sel32_q;
  logic gate_q;
  logic cfg_accept;
  logic sel_tick;
  logic gated_tick;
  logic div_wr;

  assign sel_tick   = sel32_q ? osc32_tick : osc16_tick;
  assign gated_tick = sel_tick && !gate_q;
  assign div_wr     = wr_en && (wr_addr == REG_DIV);
  assign osc_sel32  = sel32_q;

  hfosc_keylock #(
    .DATA_W    (DATA_W),
    .KEY_VALUE (KEY_VALUE)
  ) u_keylock (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .gate_off   (gate_q),
    .cfg_accept (cfg_accept),
    .prot_err   (prot_err)
  );

  hfosc_sysdiv #(
    .DIV_W   (DIV_W),
    .DIV_MAX (DIV_MAX)
  ) u_sysdiv (
    .clk        (clk),
    .rst        (rst),
    .div_wr     (div_wr),
    .div_data   (wr_data[DIV_W-1:0]),
    .sel32      (sel32_q),
    .gated_tick (gated_tick),
    .sys_tick   (sys_tick),
    .div_forced (div_forced)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel32_q   <= 1'b0;
      gate_q    <= 1'b0;
      aclk_tick <= 1'b0;
      conv_tick <= 1'b0;
    end else begin
      if (cfg_accept) sel32_q <= !wr_data[RATE_BIT];
      if (wr_en && (wr_addr == REG_GATE)) gate_q <= wr_data[0];
      aclk_tick <= gated_tick;
      conv_tick <= sel_tick;
    end
  end

  // R3: the rate only moves while the analog clock is gated off
  assert_rate_needs_gate_R3: assert property (@(posedge clk) disable iff (rst)
    !$stable(sel32_q) |-> $past(gate_q));
  // R8: gate off silences analog and system ticks
  assert_gate_blocks_R8: assert property (@(posedge clk) disable iff (rst)
    gate_q |=> (!aclk_tick && !sys_tick));
  // R7: every analog tick is matched by a converter tick
  assert_aclk_has_conv_R7: assert property (@(posedge clk) disable iff (rst)
    aclk_tick |-> conv_tick);
endmodule

// File: tb/hfosc_rate_ctrl_bench.sv
module hfosc_rate_ctrl_bench;
  localparam logic [15:0] KEY = 16'hB7E1;
  localparam int NV = 12;
  // {addr[19:18], data[17:2], exp_sel32[1], exp_err[0]}
  localparam logic [19:0] VEC [NV] = '{
    {2'd0, KEY,      1'b0, 1'b0},  // R1 arm
    {2'd2, 16'h0001, 1'b0, 1'b0},  // R8 gate off
    {2'd1, 16'h0000, 1'b1, 1'b0},  // R2 bit2=0 -> 32
    {2'd0, KEY,      1'b1, 1'b0},
    {2'd1, 16'h0004, 1'b0, 1'b0},  // R2 bit2=1 -> 16
    {2'd0, KEY,      1'b0, 1'b0},
    {2'd1, 16'hFFFB, 1'b1, 1'b0},  // R2 other bits ignored
    {2'd2, 16'h0000, 1'b1, 1'b0},  // gate on
    {2'd0, KEY,      1'b1, 1'b0},
    {2'd1, 16'h0004, 1'b1, 1'b1},  // R3 rejected while enabled
    {2'd2, 16'h0001, 1'b1, 1'b1},
    {2'd1, 16'h0004, 1'b1, 1'b1}   // R9 key already spent
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic osc16_tick = 1'b0;
  logic osc32_tick = 1'b0;
  logic osc_sel32, aclk_tick, sys_tick, conv_tick, prot_err, div_forced;

  int checks = 0;
  int errors = 0;
  int c_sys, c_aclk, c_conv;

  always #4 clk = ~clk;

  hfosc_rate_ctrl u_hfosc_rate_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .osc16_tick(osc16_tick), .osc32_tick(osc32_tick), .osc_sel32(osc_sel32),
    .aclk_tick(aclk_tick), .sys_tick(sys_tick), .conv_tick(conv_tick),
    .prot_err(prot_err), .div_forced(div_forced)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_ticks(int n, bit use32);
    c_sys = 0; c_aclk = 0; c_conv = 0;
    for (int i = 0; i < n + 3; i++) begin
      @(negedge clk);
      c_sys  += int'(sys_tick);
      c_aclk += int'(aclk_tick);
      c_conv += int'(conv_tick);
      osc16_tick = (i < n) && !use32;
      osc32_tick = (i < n) && use32;
    end
    osc16_tick = 1'b0; osc32_tick = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    chk("R4 sel32", osc_sel32, 0);
    chk("R4 err", prot_err, 0);
    chk("R4 forced", div_forced, 0);
    chk("R4 ticks", int'(aclk_tick) + int'(sys_tick) + int'(conv_tick), 0);

    for (int v = 0; v < NV; v++) begin
      wr(VEC[v][19:18], VEC[v][17:2]);
      repeat (2) @(negedge clk);
      chk($sformatf("R2/R3 vec%0d sel32", v), osc_sel32, int'(VEC[v][1]));
      chk($sformatf("R3/R9 vec%0d err", v), prot_err, int'(VEC[v][0]));
    end

    // R1/R9: wrong key does not arm, locked write flags error
    do_reset();
    wr(2'd0, 16'h1234);
    wr(2'd2, 16'h0001);
    wr(2'd1, 16'h0000);
    repeat (2) @(negedge clk);
    chk("R1 wrong key sel32", osc_sel32, 0);
    chk("R9 locked err", prot_err, 1);

    // R1: a bad key write disarms a good one
    do_reset();
    wr(2'd0, KEY);
    wr(2'd0, 16'h0000);
    wr(2'd2, 16'h0001);
    wr(2'd1, 16'h0000);
    repeat (2) @(negedge clk);
    chk("R1 disarm sel32", osc_sel32, 0);

    // R5: ratio 3 at 16 MHz
    do_reset();
    wr(2'd3, 16'd3);
    run_ticks(6, 1'b0);
    chk("R5 div3 sys", c_sys, 2);
    chk("R7 div3 aclk", c_aclk, 6);
    chk("R7 div3 conv", c_conv, 6);
    chk("R6 forced at 16", div_forced, 0);

    // R5: field 0 gives ratio 1
    wr(2'd3, 16'd0);
    run_ticks(5, 1'b0);
    chk("R5 field0 sys", c_sys, 5);

    // R5: field above 32 clamps to 32
    wr(2'd3, 16'd40);
    run_ticks(31, 1'b0);
    chk("R5 clamp 31 ticks", c_sys, 0);
    run_ticks(1, 1'b0);
    chk("R5 clamp 32nd tick", c_sys, 1);

    // R8: gate off
    wr(2'd3, 16'd1);
    wr(2'd2, 16'h0001);
    run_ticks(4, 1'b0);
    chk("R8 gated aclk", c_aclk, 0);
    chk("R8 gated sys", c_sys, 0);
    chk("R7 gated conv", c_conv, 4);

    // R6: 32 MHz with field 1 is raised to 2
    do_reset();
    wr(2'd0, KEY);
    wr(2'd2, 16'h0001);
    wr(2'd1, 16'h0000);
    wr(2'd3, 16'd1);
    wr(2'd2, 16'h0000);
    repeat (2) @(negedge clk);
    chk("R6 forced flag", div_forced, 1);
    chk("R2 sel32", osc_sel32, 1);
    run_ticks(4, 1'b1);
    chk("R6 floor sys", c_sys, 2);
    chk("R7 32 conv", c_conv, 4);
    run_ticks(4, 1'b0);
    chk("R7 unselected conv", c_conv, 0);
    chk("R7 unselected aclk", c_aclk, 0);

    // R10: divider write coinciding with a tick
    do_reset();
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd3; wr_data = 16'd1; osc16_tick = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; osc16_tick = 1'b0;
    chk("R10 conv same cycle", conv_tick, 1);
    chk("R10 sys same cycle", sys_tick, 0);
    @(negedge clk);
    chk("R10 sys after", sys_tick, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule